// File: doc/BRIEF.md
# Bit-Serial Mesh Processor Array

This block is a two-dimensional grid of one-bit processing cells, 8 rows by 8 columns by default. Every clock, one broadcast instruction (an opcode plus a memory address) reaches all cells. Each cell runs that instruction on its own pixel. A cell holds two operand registers (a vertical one and a horizontal one), a carry bit, a transfer bit and a 16-entry bit memory. Each cell also has a full adder. Words wider than one bit are handled as bit planes: an 8-bit add is a sequence of load, load and add instructions issued once per bit, from the least significant bit upward. The carry passes from one step to the next inside each cell.

Cells reach only their four nearest neighbours. The vertical register shifts one row north or south, and the horizontal register shifts one column east or west. Cells on an edge take in zero. Image planes enter and leave through a transfer chain that runs east along every row: one column of bits enters per cycle, and the last column leaves at the same time. A single global flag reports the OR of one selected register across the whole grid, for use in data-dependent decisions.

Top module: `pe_array`

## Requirements
- R1: While `rst_n` is low, and right after it rises, every register and every memory bit of every cell is 0. As a result `col_out_o` is 0 and `gor_o` is 0 for every select value.
- R2: One instruction is executed by all cells in the same cycle, each cell using its own data. After a bit-serial 8-bit add, all 64 pixels hold their own sums modulo 256.
- R3: Opcode 1 loads the vertical register from memory[addr_i]. Opcode 2 loads the horizontal register from memory[addr_i]. Opcode 3 loads the carry from memory[addr_i]. Opcode 4 stores the vertical register into memory[addr_i]. Opcode 5 stores the horizontal register into memory[addr_i].
- R4: Opcode 6 (add) writes vertical XOR horizontal XOR carry into memory[addr_i]. In the same cycle it sets the carry to the majority of those three bits.
- R5: Opcode 7 clears the carry of every cell, and opcode 8 sets it.
- R6: Opcode 9 moves each vertical register one row north (toward row 0), and the bottom row takes in 0. Opcode 10 moves it one row south, and row 0 takes in 0.
- R7: Opcode 11 moves each horizontal register one column east (toward the higher column index), and column 0 takes in 0. Opcode 12 moves it one column west, and the last column takes in 0.
- R8: Opcode 13 moves every transfer bit one column east. Column 0 of row r takes `col_in_i[r]`. `col_out_o[r]` always shows the transfer bit of the last column of row r.
- R9: Opcode 14 copies memory[addr_i] into the transfer bit. Opcode 15 copies the transfer bit into memory[addr_i]. A plane that goes in through the chain and is then read back out through it is unchanged.
- R10: `gor_o` is the OR over all cells of the register chosen by `gor_sel_i`: 0 selects vertical, 1 horizontal, 2 carry, 3 transfer.
- R11: Opcode 0 leaves every register and the whole memory of every cell unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 4 | Broadcast opcode |
| addr_i | input | 4 | Broadcast bit-memory address |
| col_in_i | input | ROWS | One bit per row entering the transfer chain at column 0 |
| gor_sel_i | input | 2 | Register chosen for the global OR |
| col_out_o | output | ROWS | Transfer bit of the last column, one per row |
| gor_o | output | 1 | Global OR of the selected register |

## Verification
The properties assume that `op_i` and `addr_i` are settled, defined values at every rising edge, and that the opcode is 0 while reset is held. The carry property also assumes that the two operand registers are loaded before an add, as bit-serial code does. The bench changes every input only on the falling edge, holds opcode 0 during reset and between tasks, and only ever uses addresses inside the 16-entry memory. Every shift, add and transfer sequence is therefore a legal instruction stream.

// File: rtl/pe_pkg.sv
package pe_pkg;

  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_LDNS = 4'd1,
    OP_LDEW = 4'd2,
    OP_LDC  = 4'd3,
    OP_STNS = 4'd4,
    OP_STEW = 4'd5,
    OP_ADD  = 4'd6,
    OP_CLRC = 4'd7,
    OP_SETC = 4'd8,
    OP_SHN  = 4'd9,
    OP_SHS  = 4'd10,
    OP_SHE  = 4'd11,
    OP_SHW  = 4'd12,
    OP_IOSH = 4'd13,
    OP_IOLD = 4'd14,
    OP_IOST = 4'd15
  } pe_op_e;

  typedef enum logic [1:0] {
    GSEL_NS = 2'd0,
    GSEL_EW = 2'd1,
    GSEL_C  = 2'd2,
    GSEL_IO = 2'd3
  } gor_sel_e;

  // full-adder sum bit
  function automatic logic fa_sum(input logic a, input logic b, input logic ci);
    return a ^ b ^ ci;
  endfunction

  // full-adder carry: majority of three
  function automatic logic fa_carry(input logic a, input logic b, input logic ci);
    return (a & b) | (a & ci) | (b & ci);
  endfunction

endpackage

// File: rtl/pe_cell.sv
module pe_cell
  import pe_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  pe_op_e        op,
  input  logic [AW-1:0] addr,
  input  logic          from_north,
  input  logic          from_south,
  input  logic          from_west,
  input  logic          from_east,
  input  logic          io_in,
  output logic          ns_o,
  output logic          ew_o,
  output logic          c_o,
  output logic          io_o
);

  logic             ns_q, ew_q, c_q, io_q;
  logic [DEPTH-1:0] mem_q;

  // named internal events
  logic mem_bit;
  logic sum_bit;
  logic carry_bit;
  logic add_fire;

  assign mem_bit   = mem_q[addr];
  assign sum_bit   = fa_sum(ns_q, ew_q, c_q);
  assign carry_bit = fa_carry(ns_q, ew_q, c_q);
  assign add_fire  = (op == OP_ADD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ns_q  <= 1'b0;
      ew_q  <= 1'b0;
      c_q   <= 1'b0;
      io_q  <= 1'b0;
      mem_q <= '0;
    end else begin
      case (op)
        OP_LDNS: ns_q <= mem_bit;
        OP_LDEW: ew_q <= mem_bit;
        OP_LDC:  c_q  <= mem_bit;
        OP_STNS: mem_q[addr] <= ns_q;
        OP_STEW: mem_q[addr] <= ew_q;
        OP_ADD: begin
          mem_q[addr] <= sum_bit;
          c_q         <= carry_bit;
        end
        OP_CLRC: c_q  <= 1'b0;
        OP_SETC: c_q  <= 1'b1;
        OP_SHN:  ns_q <= from_south;
        OP_SHS:  ns_q <= from_north;
        OP_SHE:  ew_q <= from_west;
        OP_SHW:  ew_q <= from_east;
        OP_IOSH: io_q <= io_in;
        OP_IOLD: io_q <= mem_bit;
        OP_IOST: mem_q[addr] <= io_q;
        default: ;
      endcase
    end
  end

  assign ns_o = ns_q;
  assign ew_o = ew_q;
  assign c_o  = c_q;
  assign io_o = io_q;

  // equal operands decide the carry on their own, whatever the old carry was
  AST_CARRY_DECIDED: assert property (@(posedge clk) disable iff (!rst_n)
    (add_fire && (ns_q == ew_q)) |=> (c_q == $past(ns_q))); // R4

  AST_CARRY_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_CLRC) |=> !c_q); // R5

  AST_CARRY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SETC) |=> c_q); // R5

  AST_STORE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_STNS) |=> (mem_q[$past(addr)] == $past(ns_q))); // R3

endmodule

// File: rtl/pe_gor.sv
module pe_gor
  import pe_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  localparam int N = ROWS * COLS
) (
  input  gor_sel_e     sel,
  input  logic [N-1:0] ns_v,
  input  logic [N-1:0] ew_v,
  input  logic [N-1:0] c_v,
  input  logic [N-1:0] io_v,
  output logic         any_o
);

  logic [N-1:0]    pick;
  logic [ROWS-1:0] row_any;

  always_comb begin
    case (sel)
      GSEL_NS: pick = ns_v;
      GSEL_EW: pick = ew_v;
      GSEL_C:  pick = c_v;
      default: pick = io_v;
    endcase
  end

  // two-level reduction: per row, then across rows
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign row_any[r] = |pick[r*COLS +: COLS];
  end

  assign any_o = |row_any;

endmodule

// File: rtl/pe_array.sv
module pe_array
  import pe_pkg::*;
#(
  parameter int ROWS  = 8,
  parameter int COLS  = 8,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int N  = ROWS * COLS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      op_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [ROWS-1:0] col_in_i,
  input  logic [1:0]      gor_sel_i,
  output logic [ROWS-1:0] col_out_o,
  output logic            gor_o
);

  pe_op_e op;
  assign op = pe_op_e'(op_i);

  logic ns_w [ROWS][COLS];
  logic ew_w [ROWS][COLS];
  logic c_w  [ROWS][COLS];
  logic io_w [ROWS][COLS];

  logic [N-1:0] ns_flat, ew_flat, c_flat, io_flat;

  for (genvar r = 0; r < ROWS; r++) begin : g_r
    for (genvar c = 0; c < COLS; c++) begin : g_c
      logic nb_n, nb_s, nb_w, nb_e, nb_io;

      if (r == 0) begin : g_top
        assign nb_n = 1'b0;
      end else begin : g_top_n
        assign nb_n = ns_w[r-1][c];
      end
      if (r == ROWS-1) begin : g_bot
        assign nb_s = 1'b0;
      end else begin : g_bot_n
        assign nb_s = ns_w[r+1][c];
      end
      if (c == 0) begin : g_lft
        assign nb_w  = 1'b0;
        assign nb_io = col_in_i[r];
      end else begin : g_lft_n
        assign nb_w  = ew_w[r][c-1];
        assign nb_io = io_w[r][c-1];
      end
      if (c == COLS-1) begin : g_rgt
        assign nb_e = 1'b0;
      end else begin : g_rgt_n
        assign nb_e = ew_w[r][c+1];
      end

      pe_cell #(.DEPTH(DEPTH)) u_cell (
        .clk        (clk),
        .rst_n      (rst_n),
        .op         (op),
        .addr       (addr_i),
        .from_north (nb_n),
        .from_south (nb_s),
        .from_west  (nb_w),
        .from_east  (nb_e),
        .io_in      (nb_io),
        .ns_o       (ns_w[r][c]),
        .ew_o       (ew_w[r][c]),
        .c_o        (c_w[r][c]),
        .io_o       (io_w[r][c])
      );

      assign ns_flat[r*COLS+c] = ns_w[r][c];
      assign ew_flat[r*COLS+c] = ew_w[r][c];
      assign c_flat[r*COLS+c]  = c_w[r][c];
      assign io_flat[r*COLS+c] = io_w[r][c];
    end

    assign col_out_o[r] = io_w[r][COLS-1];
  end

  pe_gor #(.ROWS(ROWS), .COLS(COLS)) u_gor (
    .sel   (gor_sel_e'(gor_sel_i)),
    .ns_v  (ns_flat),
    .ew_v  (ew_flat),
    .c_v   (c_flat),
    .io_v  (io_flat),
    .any_o (gor_o)
  );

  // ---------------- array-level properties ----------------
  AST_SOUTH_EDGE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SHN) |=> (ns_flat[(ROWS-1)*COLS +: COLS] == '0)); // R6

  AST_NORTH_EDGE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SHS) |=> (ns_flat[COLS-1:0] == '0)); // R6

  logic [ROWS-1:0] ew_col0, ew_last;
  logic [ROWS-1:0] io_prev_col;
  for (genvar r = 0; r < ROWS; r++) begin : g_cols
    assign ew_col0[r] = ew_w[r][0];
    assign ew_last[r] = ew_w[r][COLS-1];
    if (COLS > 1) begin : g_pc
      assign io_prev_col[r] = io_w[r][COLS-2];
    end else begin : g_pc1
      assign io_prev_col[r] = col_in_i[r];
    end
  end

  AST_WEST_EDGE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SHE) |=> (ew_col0 == '0)); // R7

  AST_EAST_EDGE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SHW) |=> (ew_last == '0)); // R7

  AST_CHAIN_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_IOSH) |=> (col_out_o == $past(io_prev_col))); // R8

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_NOP) |=> ($stable(ns_flat) && $stable(ew_flat)
                        && $stable(c_flat) && $stable(io_flat))); // R11

endmodule

// File: tb/sim_pe_array.sv
`timescale 1ns/1ps
module sim_pe_array;
  import pe_pkg::*;

  localparam int ROWS = 8;
  localparam int COLS = 8;
  localparam int NPIX = ROWS * COLS;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] op_i = 4'd0;
  logic [3:0] addr_i = 4'd0;
  logic [7:0] col_in_i = 8'd0;
  logic [1:0] gor_sel_i = 2'd0;
  logic [7:0] col_out_o;
  logic       gor_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  pe_array #(.ROWS(ROWS), .COLS(COLS), .DEPTH(16)) u0 (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .addr_i(addr_i),
    .col_in_i(col_in_i), .gor_sel_i(gor_sel_i),
    .col_out_o(col_out_o), .gor_o(gor_o)
  );

  // each entry: {mulA, addA, mulB, addB}; pixel = idx*mul + add (mod 256)
  localparam logic [31:0] VEC [0:3] = '{
    32'h01_00_01_00,
    32'h25_0B_5B_C8,
    32'h00_FF_00_01,
    32'h03_07_FD_05
  };

  function automatic logic [7:0] pix(input logic [7:0] mul, input logic [7:0] add, input int idx);
    return 8'(idx * int'(mul) + int'(add));
  endfunction

  // expected plane after a neighbour move; bit index = row*8 + col
  function automatic logic [63:0] moved(input logic [63:0] p, input int dir);
    logic [63:0] q;
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        case (dir)
          0: q[r*COLS+c] = (r == ROWS-1) ? 1'b0 : p[(r+1)*COLS+c]; // north
          1: q[r*COLS+c] = (r == 0)      ? 1'b0 : p[(r-1)*COLS+c]; // south
          2: q[r*COLS+c] = (c == 0)      ? 1'b0 : p[r*COLS+c-1];   // east
          default: q[r*COLS+c] = (c == COLS-1) ? 1'b0 : p[r*COLS+c+1]; // west
        endcase
      end
    end
    return q;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input pe_op_e op, input logic [3:0] a);
    op_i = op;
    addr_i = a;
    @(negedge clk);
    op_i = OP_NOP;
    col_in_i = '0;
  endtask

  task automatic load_plane(input logic [63:0] p, input logic [3:0] a);
    for (int k = 0; k < COLS; k++) begin
      for (int r = 0; r < ROWS; r++) col_in_i[r] = p[r*COLS + COLS-1-k];
      issue(OP_IOSH, 4'd0);
    end
    issue(OP_IOST, a);
  endtask

  task automatic unload_plane(input logic [3:0] a, output logic [63:0] p);
    issue(OP_IOLD, a);
    for (int k = 0; k < COLS; k++) begin
      for (int r = 0; r < ROWS; r++) p[r*COLS + COLS-1-k] = col_out_o[r];
      issue(OP_IOSH, 4'd0);
    end
  endtask

  task automatic gor_is(input logic [1:0] s, input logic exp, input string req);
    gor_sel_i = s;
    #0.1;
    chk(gor_o == exp, req, 64'(gor_o), 64'(exp));
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] pl, got;
    logic [7:0]  ea [NPIX];
    logic [7:0]  eb [NPIX];
    logic [7:0]  gs [NPIX];
    logic        any_carry;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk(col_out_o == 8'd0, "R1 chain output after reset", 64'(col_out_o), 64'd0);
    for (int s = 0; s < 4; s++) gor_is(2'(s), 1'b0, "R1 R10 global flag after reset");
    unload_plane(4'd9, got);
    chk(got == 64'd0, "R1 memory cleared by reset", got, 64'd0);

    // table-driven bit-serial adds (R2, R3, R4, R8, R9)
    for (int v = 0; v < 4; v++) begin
      any_carry = 1'b0;
      for (int i = 0; i < NPIX; i++) begin
        ea[i] = pix(VEC[v][31:24], VEC[v][23:16], i);
        eb[i] = pix(VEC[v][15:8],  VEC[v][7:0],   i);
        if ((9'(ea[i]) + 9'(eb[i])) > 9'd255) any_carry = 1'b1;
      end
      for (int b = 0; b < 8; b++) begin
        for (int i = 0; i < NPIX; i++) pl[i] = ea[i][b];
        load_plane(pl, 4'(b));
        for (int i = 0; i < NPIX; i++) pl[i] = eb[i][b];
        load_plane(pl, 4'(8 + b));
      end
      issue(OP_CLRC, 4'd0);
      for (int b = 0; b < 8; b++) begin
        issue(OP_LDNS, 4'(b));
        issue(OP_LDEW, 4'(8 + b));
        issue(OP_ADD, 4'(b));
      end
      gor_is(2'd2, any_carry, "R4 R10 final carry flag");
      for (int b = 0; b < 8; b++) begin
        unload_plane(4'(b), got);
        for (int i = 0; i < NPIX; i++) gs[i][b] = got[i];
      end
      for (int i = 0; i < NPIX; i++)
        chk(gs[i] == ea[i] + eb[i], "R2 R4 per-pixel sum", 64'(gs[i]), 64'(8'(ea[i] + eb[i])));
    end

    // R8 R9: chain round trip
    pl = 64'hA5C3_0F1E_7788_B42D;
    load_plane(pl, 4'd5);
    unload_plane(4'd5, got);
    chk(got == pl, "R8 R9 transfer round trip", got, pl);

    // R6: vertical moves
    issue(OP_LDNS, 4'd5); issue(OP_SHN, 4'd0); issue(OP_STNS, 4'd6);
    unload_plane(4'd6, got);
    chk(got == moved(pl, 0), "R6 move north", got, moved(pl, 0));
    issue(OP_LDNS, 4'd5); issue(OP_SHS, 4'd0); issue(OP_STNS, 4'd6);
    unload_plane(4'd6, got);
    chk(got == moved(pl, 1), "R6 move south", got, moved(pl, 1));

    // R7: horizontal moves
    issue(OP_LDEW, 4'd5); issue(OP_SHE, 4'd0); issue(OP_STEW, 4'd6);
    unload_plane(4'd6, got);
    chk(got == moved(pl, 2), "R7 move east", got, moved(pl, 2));
    issue(OP_LDEW, 4'd5); issue(OP_SHW, 4'd0); issue(OP_STEW, 4'd6);
    unload_plane(4'd6, got);
    chk(got == moved(pl, 3), "R7 move west", got, moved(pl, 3));

    // R6 R7 edge: all-ones plane, north then west clears bottom row / last column
    load_plane(64'hFFFF_FFFF_FFFF_FFFF, 4'd7);
    issue(OP_LDNS, 4'd7); issue(OP_SHN, 4'd0); issue(OP_STNS, 4'd6);
    unload_plane(4'd6, got);
    chk(got == 64'h00FF_FFFF_FFFF_FFFF, "R6 bottom row fills zero", got, 64'h00FF_FFFF_FFFF_FFFF);
    issue(OP_LDEW, 4'd7); issue(OP_SHW, 4'd0); issue(OP_STEW, 4'd6);
    unload_plane(4'd6, got);
    chk(got == 64'h7F7F_7F7F_7F7F_7F7F, "R7 last column fills zero", got, 64'h7F7F_7F7F_7F7F_7F7F);

    // R11: idle cycles keep registers and memory
    issue(OP_LDNS, 4'd5);
    for (int k = 0; k < 5; k++) issue(OP_NOP, 4'(k));
    issue(OP_STNS, 4'd6);
    unload_plane(4'd6, got);
    chk(got == pl, "R11 idle keeps vertical register", got, pl);
    unload_plane(4'd5, got);
    chk(got == pl, "R11 idle keeps memory", got, pl);

    // R10: global OR on a single corner bit, and on an empty plane
    load_plane(64'h8000_0000_0000_0000, 4'd3);
    load_plane(64'd0, 4'd4);
    issue(OP_IOLD, 4'd3);
    gor_is(2'd3, 1'b1, "R10 flag sees single transfer bit");
    issue(OP_LDNS, 4'd3);
    gor_is(2'd0, 1'b1, "R10 flag sees single vertical bit");
    issue(OP_LDEW, 4'd4);
    gor_is(2'd1, 1'b0, "R10 flag on empty horizontal plane");
    issue(OP_IOLD, 4'd4);
    gor_is(2'd3, 1'b0, "R10 flag on empty transfer plane");

    // R3: carry load from memory
    issue(OP_LDC, 4'd4);
    gor_is(2'd2, 1'b0, "R3 carry loaded from empty plane");
    issue(OP_LDC, 4'd3);
    gor_is(2'd2, 1'b1, "R3 carry loaded from corner plane");

    // R5: carry set / clear
    issue(OP_SETC, 4'd0);
    gor_is(2'd2, 1'b1, "R5 carry set");
    issue(OP_CLRC, 4'd0);
    gor_is(2'd2, 1'b0, "R5 carry clear");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule